// File: doc/BRIEF.md
# Oversampled NRZ bit-timing recovery

This block recovers bit timing and data from a non-return-to-zero serial line, given a local clock at eight times the nominal bit rate. For a line at 6.9375 Mbit/s that clock is 55.5 MHz. The raw line is first brought into the local clock domain. A one-clock toggle pulse then marks each change of level. That pulse restarts a modulo-8 phase counter.

When the counter reaches mid-bit, the block raises a one-cycle strobe and captures the line level as the recovered bit. There is no feedback loop. Between edges the counter free-runs and depends on both ends being within tens of ppm of the nominal rate. That drift stays far below one sample over the longest legal run of 14 identical bits. Edges may also arrive back to back, one per bit, as in an alternating run-in.

An activity flag shows whether the line has toggled within the last 32 bit times.

Top module: `ocr_clock_recovery`

## Requirements
- R1: While rst is high, bit_out, bit_valid and active are all 0. After the last clock edge with rst high, the phase counter starts at 0, and bit_valid first pulses after the 4th rising edge that follows.
- R2: rx_raw passes through a two-flop synchronizer. If rx_raw, sampled at edge k, differs from its value at edge k-1, the phase restarts. The next bit_valid pulse follows edge k+6, and no pulse appears after edges k+1 to k+5.
- R3: While no transition arrives, bit_valid keeps pulsing every OSR = 8 clocks without limit, so that runs of 14 or more identical bits are still strobed.
- R4: bit_valid is high for exactly one cycle per strobe. When it rises after edge n, bit_out takes the rx_raw value sampled at edge n-2. Between strobes bit_out does not change.
- R5: Each transmitted bit is recovered exactly once and in order, with its correct value. This holds for bits lasting 6 to 10 clocks: 8 nominal, transition jitter of ±1 clock, and a rate offset of ±25 ppm.
- R6: A transition sampled at edge k drives active to 1 from edge k+2 onward.
- R7: After 32 × OSR = 256 clocks with no transition, active returns to 0. For a last transition sampled at edge k, it is cleared at edge k+258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_raw | input | 1 | Unsynchronized NRZ serial line |
| bit_out | output | 1 | Most recently recovered bit |
| bit_valid | output | 1 | One-cycle strobe marking a new value on bit_out |
| active | output | 1 | High while the line has toggled within the last 32 bit times |

## Verification
The hardest case to reach from the ports is a bit whose start edge is displaced by one clock, followed by a 14-bit run with no transitions. In that case the free-running counter must still strobe every bit exactly once, with no doubled or skipped sample. The bench builds packets of an alternating run-in, a sync byte and the repeating pattern 1111 1110 0111 1111. It places every bit boundary on a computed timeline with a ±25 ppm offset and pseudo-random ±1-clock jitter. It then tracks which transmitted bit index each strobe sampled. Long idle gaps between packets drive the activity timer past its limit and then wake it with the next packet's first edge.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

    // Synchronized line level together with its one-clock change marker
    typedef struct packed {
        logic level;
        logic toggle;
    } line_ev_t;

    // Mid-bit sample event and the captured value
    typedef struct packed {
        logic fire;
        logic value;
    } strobe_t;

    // Idle timeout expressed in fast clocks
    function automatic int idle_clocks(int bits, int osr);
        return bits * osr;
    endfunction

endpackage

// File: rtl/ocr_sync.sv
module ocr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/ocr_edge_det.sv
module ocr_edge_det
    import ocr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    output line_ev_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
        end else begin
            prev <= level;
        end
    end

    assign ev.level  = level;
    assign ev.toggle = level ^ prev;

endmodule

// File: rtl/ocr_phase_gen.sv
module ocr_phase_gen
    import ocr_pkg::*;
#(
    parameter int OSR          = 8,
    parameter int SAMPLE_PHASE = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output strobe_t  stb
);
    localparam int PW = $clog2(OSR);
    localparam logic [PW-1:0] LAST_PH = PW'(OSR - 1);
    localparam logic [PW-1:0] MID_PH  = PW'(SAMPLE_PHASE);

    logic [PW-1:0] ph;
    logic [PW-1:0] ph_nx;

    always_comb begin
        if (ev.toggle) begin
            ph_nx = '0;
        end else if (ph == LAST_PH) begin
            ph_nx = '0;
        end else begin
            ph_nx = ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= '0;
            stb <= '0;
        end else begin
            ph       <= ph_nx;
            stb.fire <= (ph_nx == MID_PH);
            if (ph_nx == MID_PH) begin
                stb.value <= ev.level;
            end
        end
    end

    AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (rst)
        ev.toggle |=> !stb.fire); // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        stb.fire |=> !stb.fire); // R4
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
        !stb.fire |-> $stable(stb.value)); // R4

endmodule

// File: rtl/ocr_activity.sv
module ocr_activity #(
    parameter int IDLE_CLKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    output logic active
);
    localparam int CW = $clog2(IDLE_CLKS + 1);
    localparam logic [CW-1:0] SAT  = CW'(IDLE_CLKS);
    localparam logic [CW-1:0] LIM1 = CW'(IDLE_CLKS - 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= SAT;
            active    <= 1'b0;
        end else if (toggle) begin
            quiet_cnt <= '0;
            active    <= 1'b1;
        end else if (quiet_cnt != SAT) begin
            quiet_cnt <= quiet_cnt + 1'b1;
            if (quiet_cnt == LIM1) begin
                active <= 1'b0;
            end
        end
    end

    AST_WAKE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        toggle |=> active); // R6
    AST_SLEEP_NOT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> !$past(toggle)); // R7

endmodule

// File: rtl/ocr_clock_recovery.sv
module ocr_clock_recovery
    import ocr_pkg::*;
#(
    parameter int OSR          = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int IDLE_BITS    = 32,
    parameter int SAMPLE_PHASE = OSR / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    output logic bit_out,
    output logic bit_valid,
    output logic active
);
    localparam int IDLE_CLKS = idle_clocks(IDLE_BITS, OSR);

    logic     rx_sync;
    line_ev_t line_ev;
    strobe_t  sample;

    ocr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_raw),
        .dout (rx_sync)
    );

    ocr_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (rx_sync),
        .ev    (line_ev)
    );

    ocr_phase_gen #(.OSR(OSR), .SAMPLE_PHASE(SAMPLE_PHASE)) u_phase (
        .clk (clk),
        .rst (rst),
        .ev  (line_ev),
        .stb (sample)
    );

    ocr_activity #(.IDLE_CLKS(IDLE_CLKS)) u_act (
        .clk    (clk),
        .rst    (rst),
        .toggle (line_ev.toggle),
        .active (active)
    );

    assign bit_out   = sample.value;
    assign bit_valid = sample.fire;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!bit_valid && !active && !bit_out)); // R1

endmodule

// File: tb/tb_ocr_clock_recovery.sv
module tb_ocr_clock_recovery;
    localparam int OSR  = 8;
    localparam int IDLE = 32 * OSR;
    localparam int H    = 4096;
    localparam int NB   = 88;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b0;
    logic bit_out, bit_valid, active;

    always #4 clk = ~clk;

    ocr_clock_recovery dut (
        .clk       (clk),
        .rst       (rst),
        .rx_raw    (rx),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .active    (active)
    );

    int n = 0;
    int dh [H];
    int ih [H];
    int cur_idx = -1;
    int last_tr = 0;
    bit seen = 0;
    bit ev = 0, eb = 0, ea = 0;
    int compared = 0, mismatched = 0;
    string req_v = "R1";
    string req_a = "R6";
    int pkt [NB];
    int jit [NB+1];
    int pk_last = -1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: expected outputs after each rising edge
    always @(posedge clk) begin
        n = n + 1;
        dh[n % H] = rst ? 0 : (rx ? 1 : 0);
        ih[n % H] = cur_idx;
        if (rst) begin
            last_tr = n - 2;
            seen = 0;
            ev = 0; eb = 0; ea = 0;
        end else begin
            if (n >= 3 && dh[(n-2) % H] != dh[(n-3) % H]) begin
                last_tr = n - 2;
                seen = 1;
            end
            ev = (n - last_tr >= 6) && ((n - last_tr - 6) % OSR == 0);
            if (ev) eb = (dh[(n-2) % H] != 0);
            ea = seen && (n - last_tr - 2 < IDLE);
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        int o;
        if (n >= 3) begin
            check(bit_valid == ev, req_v, "bit_valid", int'(bit_valid), int'(ev));
            check(bit_out == eb, "R4", "bit_out", int'(bit_out), int'(eb));
            check(active == ea, req_a, "active", int'(active), int'(ea));
            if (!rst && bit_valid && ih[(n-2) % H] >= 0) begin
                o = ih[(n-2) % H];
                check(o == pk_last + 1, "R5", "sampled bit index", o, pk_last + 1);
                check(int'(bit_out) == pkt[o], "R5", "recovered bit", int'(bit_out), pkt[o]);
                pk_last = o;
            end
        end
    end

    task automatic idle(int cyc, bit lvl);
        repeat (cyc) begin
            @(negedge clk);
            rx = lvl;
            cur_idx = -1;
        end
    endtask

    task automatic send(int ppm, bit jit_on);
        int b [NB+1];
        int k;
        for (int i = 0; i <= NB; i++) begin
            b[i] = i * OSR + (i * OSR * ppm) / 1000000 + ((jit_on && i > 0) ? jit[i] : 0);
        end
        k = 0;
        pk_last = -1;
        for (int t = 0; t < b[NB]; t++) begin
            while (k < NB - 1 && t >= b[k+1]) k++;
            @(negedge clk);
            rx = (pkt[k] != 0);
            cur_idx = k;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL R5 watchdog: actual %0d expected %0d", n, 0);
        summary();
        $finish;
    end

    initial begin
        int lfsr;
        int pat;
        pat = 16'hFE7F;
        for (int k = 0; k < 16; k++) pkt[k] = (k % 2 == 0) ? 1 : 0;
        for (int k = 0; k < 8; k++) pkt[16+k] = (8'hE4 >> (7 - k)) & 1;
        for (int k = 0; k < 64; k++) pkt[24+k] = (pat >> (15 - (k % 16))) & 1;
        lfsr = 16'hACE1;
        for (int k = 0; k <= NB; k++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
            jit[k] = (lfsr % 3) - 1;
        end

        rst = 1'b1;
        rx  = 1'b0;
        repeat (4) @(negedge clk);
        check(!bit_valid && !active && !bit_out, "R1", "outputs in reset",
              int'({bit_valid, active, bit_out}), 0);
        rst = 1'b0;
        req_v = "R1";
        idle(60, 1'b0);
        check(active == 1'b0, "R6", "active before any transition", int'(active), 0);

        req_v = "R2"; req_a = "R6";
        send(0, 1'b0);
        idle(20, 1'b0);
        check(pk_last == NB - 1, "R5", "last index, exact rate", pk_last, NB - 1);
        check(active == 1'b1, "R6", "active after packet", int'(active), 1);

        req_v = "R3"; req_a = "R7";
        idle(300, 1'b0);
        check(active == 1'b0, "R7", "active after long idle", int'(active), 0);

        req_v = "R2"; req_a = "R6";
        send(25, 1'b1);
        idle(20, 1'b0);
        check(pk_last == NB - 1, "R5", "last index, +25 ppm jitter", pk_last, NB - 1);

        req_v = "R3"; req_a = "R7";
        idle(300, 1'b0);
        check(active == 1'b0, "R7", "active after second idle", int'(active), 0);

        req_v = "R2"; req_a = "R6";
        send(-25, 1'b1);
        idle(20, 1'b0);
        check(pk_last == NB - 1, "R5", "last index, -25 ppm jitter", pk_last, NB - 1);

        req_v = "R3"; req_a = "R7";
        idle(300, 1'b0);
        check(active == 1'b0, "R7", "active after final idle", int'(active), 0);

        summary();
        $finish;
    end

endmodule